// File: doc/BRIEF.md
# TLB Refill Page-Table Walker

This block services a translation miss by walking a single-level page table in hardware. When the requester reports a missing virtual address, the walker builds the address of the page-table entry (PTE) from a base value and the missing address. It asks the TLB lookup block to translate that PTE address as a privileged load. It then reads the 32-bit PTE from memory and writes a new 4 KB mapping into one of the four refill ways of the TLB.

The translation of the PTE address never starts a second walk. If that probe misses, or if the memory read returns an error, the walk ends with a fault that carries the cause code the requester supplied with the miss. Only one walk is in progress at a time. A successful walk also records the missing address in an exception-address register, which is held on an output.

The refill way is picked by a two-bit round-robin counter that advances before each write. The first refill after reset therefore lands in way 1.

Top module: `ptw_refill_walker`

## Requirements
- R1: One cycle after a miss is accepted, `probe_req` pulses for one cycle with `probe_va` = (`pte_base` OR (`miss_vaddr` >> 10)) with bits [1:0] forced to 0.
- R2: If the probe answer has `probe_hit`=0, `fault` pulses on the cycle after the answer with `fault_cause` equal to the cause latched at acceptance, and no memory request is made.
- R3: If the PTE read returns `mem_rsp_err`=1, `fault` pulses on the next cycle with the latched cause, and `wr_en` stays 0.
- R4: On a good PTE, `wr_en` pulses one cycle after the response with `wr_index` = vaddr[13:12], `wr_vpn` = vaddr[31:12], `wr_ppn` = PTE[31:12], `wr_attr` = PTE[3:0], and `wr_asid` = byte k of `ring_asids`, where k = PTE[5:4] and byte k is bits [8k+7:8k].
- R5: `wr_way` comes from a two-bit counter that is 0 after reset and is incremented before each write. The writes after reset go to ways 1, 2, 3, 0, 1 and so on. Faulted walks do not advance it.
- R6: `excv_addr` takes the missing address in the same cycle that `done` pulses, and does not change at any other time, including on a fault.
- R7: `busy` rises in the cycle after a miss is accepted and falls in the cycle that `done` or `fault` pulses. A `miss_valid` seen while busy is ignored.
- R8: `done` and `fault` are one-cycle pulses and are never high together. `done` follows `wr_en` by one cycle.
- R9: After a probe hit, `mem_req_valid` rises with `mem_req_addr` = `probe_pa`, and both hold until `mem_req_ready` is sampled high.
- R10: After reset, `busy`, `done`, `fault`, `probe_req`, `mem_req_valid`, `wr_en` and `excv_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pte_base | input | 32 | Page-table base value |
| ring_asids | input | 32 | Four ASID bytes, byte k for ring k |
| miss_valid | input | 1 | Miss report from the requester |
| miss_vaddr | input | 32 | Missing virtual address |
| miss_cause | input | 6 | Cause code to return on a fault |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Refill complete (pulse) |
| fault | output | 1 | Walk aborted (pulse) |
| fault_cause | output | 6 | Cause code returned with a fault |
| excv_addr | output | 32 | Exception-address register |
| probe_req | output | 1 | Translation probe request (pulse) |
| probe_va | output | 32 | PTE virtual address to translate |
| probe_rsp_valid | input | 1 | Probe answer is valid |
| probe_hit | input | 1 | Probe hit with ring-0 load access |
| probe_pa | input | 32 | Translated PTE physical address |
| mem_req_valid | output | 1 | PTE read request |
| mem_req_addr | output | 32 | PTE physical address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | PTE word |
| mem_rsp_err | input | 1 | Read failed |
| wr_en | output | 1 | TLB write strobe |
| wr_way | output | 2 | Refill way |
| wr_index | output | 2 | Entry index within the way |
| wr_vpn | output | 20 | Virtual page number |
| wr_ppn | output | 20 | Physical page number |
| wr_asid | output | 8 | ASID of the new mapping |
| wr_attr | output | 4 | Attribute bits |

## Verification
Every output is a register, so each result appears one edge after the input that caused it. The probe appears one cycle after the miss is accepted. The memory request, or a probe fault, appears one cycle after the probe answer. The TLB write, or a memory fault, appears one cycle after the read data. `done` and the new exception address appear one cycle after the write. The bench plays both the lookup block and the memory itself, drives each answer on a falling edge, and reads each result on the falling edge right after the rising edge that must produce it. A mismatch in cycle placement therefore shows up as a value mismatch.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLATE_PTE,
    ST_MEM_REQ,
    ST_MEM_WAIT,
    ST_INSTALL
  } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int PTE_SHIFT = 10,
  parameter int ALIGN_LG  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] vaddr,
  output logic [ADDR_W-1:0] pte_va
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << ALIGN_LG;

  always_comb begin
    pte_va = (base | (vaddr >> PTE_SHIFT)) & ALIGN_MASK;
  end
endmodule

// File: rtl/ptw_entry_fmt.sv
module ptw_entry_fmt #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 2,
  parameter int ASID_W     = 8,
  parameter int RINGS      = 4,
  parameter int ATTR_W     = 4
) (
  input  logic [ADDR_W-1:0]         vaddr,
  input  logic [ADDR_W-1:PAGE_SHIFT] pte_ppn,
  input  logic [$clog2(RINGS)-1:0]  pte_ring,
  input  logic [ATTR_W-1:0]         pte_attr,
  input  logic [RINGS*ASID_W-1:0]   ring_asids,
  output logic [IDX_W-1:0]          idx,
  output logic [ADDR_W-PAGE_SHIFT-1:0] vpn,
  output logic [ADDR_W-PAGE_SHIFT-1:0] ppn,
  output logic [ASID_W-1:0]         asid,
  output logic [ATTR_W-1:0]         attr
);
  logic [ASID_W-1:0] asid_by_ring [RINGS];

  for (genvar g = 0; g < RINGS; g++) begin : g_ring
    assign asid_by_ring[g] = ring_asids[g*ASID_W +: ASID_W];
  end

  always_comb begin
    idx  = vaddr[PAGE_SHIFT +: IDX_W];
    vpn  = vaddr[ADDR_W-1:PAGE_SHIFT];
    ppn  = pte_ppn;
    asid = asid_by_ring[pte_ring];
    attr = pte_attr;
  end
endmodule

// File: rtl/ptw_rr_way.sv
module ptw_rr_way #(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [WAY_W-1:0] way_next
);
  logic [WAY_W-1:0] cnt;

  assign way_next = cnt + WAY_W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= way_next;
  end

  AST_WAY_STEP: assert property (@(posedge clk) disable iff (rst)
    inc |=> (cnt == WAY_W'($past(cnt) + 1)));  // R5
endmodule

// File: rtl/ptw_refill_walker.sv
module ptw_refill_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 2,
  parameter int WAY_W      = 2,
  parameter int ASID_W     = 8,
  parameter int RINGS      = 4,
  parameter int ATTR_W     = 4,
  parameter int CAUSE_W    = 6,
  parameter int PTE_SHIFT  = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            pte_base,
  input  logic [RINGS*ASID_W-1:0]      ring_asids,
  input  logic                         miss_valid,
  input  logic [ADDR_W-1:0]            miss_vaddr,
  input  logic [CAUSE_W-1:0]           miss_cause,
  output logic                         busy,
  output logic                         done,
  output logic                         fault,
  output logic [CAUSE_W-1:0]           fault_cause,
  output logic [ADDR_W-1:0]            excv_addr,
  output logic                         probe_req,
  output logic [ADDR_W-1:0]            probe_va,
  input  logic                         probe_rsp_valid,
  input  logic                         probe_hit,
  input  logic [ADDR_W-1:0]            probe_pa,
  output logic                         mem_req_valid,
  output logic [ADDR_W-1:0]            mem_req_addr,
  input  logic                         mem_req_ready,
  input  logic                         mem_rsp_valid,
  input  logic [ADDR_W-1:0]            mem_rsp_data,
  input  logic                         mem_rsp_err,
  output logic                         wr_en,
  output logic [WAY_W-1:0]             wr_way,
  output logic [IDX_W-1:0]             wr_index,
  output logic [ADDR_W-PAGE_SHIFT-1:0] wr_vpn,
  output logic [ADDR_W-PAGE_SHIFT-1:0] wr_ppn,
  output logic [ASID_W-1:0]            wr_asid,
  output logic [ATTR_W-1:0]            wr_attr
);
  localparam int RING_W = $clog2(RINGS);
  localparam int VPN_W  = ADDR_W - PAGE_SHIFT;

  walk_state_t         state;
  logic [ADDR_W-1:0]   vaddr_q;
  logic [CAUSE_W-1:0]  cause_q;
  logic [ADDR_W-1:0]   pte_va_c;
  logic [IDX_W-1:0]    idx_c;
  logic [VPN_W-1:0]    vpn_c;
  logic [VPN_W-1:0]    ppn_c;
  logic [ASID_W-1:0]   asid_c;
  logic [ATTR_W-1:0]   attr_c;
  logic [WAY_W-1:0]    way_next;
  logic                refill_ok;

  ptw_addr_gen #(
    .ADDR_W(ADDR_W), .PTE_SHIFT(PTE_SHIFT), .ALIGN_LG(2)
  ) u_addr (
    .base(pte_base), .vaddr(miss_vaddr), .pte_va(pte_va_c)
  );

  ptw_entry_fmt #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W),
    .ASID_W(ASID_W), .RINGS(RINGS), .ATTR_W(ATTR_W)
  ) u_fmt (
    .vaddr(vaddr_q),
    .pte_ppn(mem_rsp_data[ADDR_W-1:PAGE_SHIFT]),
    .pte_ring(mem_rsp_data[4 +: RING_W]),
    .pte_attr(mem_rsp_data[ATTR_W-1:0]),
    .ring_asids(ring_asids),
    .idx(idx_c), .vpn(vpn_c), .ppn(ppn_c), .asid(asid_c), .attr(attr_c)
  );

  assign refill_ok = (state == ST_MEM_WAIT) && mem_rsp_valid && !mem_rsp_err;

  ptw_rr_way #(.WAY_W(WAY_W)) u_way (
    .clk(clk), .rst(rst), .inc(refill_ok), .way_next(way_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      vaddr_q       <= '0;
      cause_q       <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
      fault         <= 1'b0;
      fault_cause   <= '0;
      excv_addr     <= '0;
      probe_req     <= 1'b0;
      probe_va      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      wr_en         <= 1'b0;
      wr_way        <= '0;
      wr_index      <= '0;
      wr_vpn        <= '0;
      wr_ppn        <= '0;
      wr_asid       <= '0;
      wr_attr       <= '0;
    end else begin
      done      <= 1'b0;
      fault     <= 1'b0;
      probe_req <= 1'b0;
      wr_en     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (miss_valid) begin
            vaddr_q   <= miss_vaddr;
            cause_q   <= miss_cause;
            probe_va  <= pte_va_c;
            probe_req <= 1'b1;
            busy      <= 1'b1;
            state     <= ST_XLATE_PTE;
          end
        end
        ST_XLATE_PTE: begin
          if (probe_rsp_valid) begin
            if (probe_hit) begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= probe_pa;
              state         <= ST_MEM_REQ;
            end else begin
              fault       <= 1'b1;
              fault_cause <= cause_q;
              busy        <= 1'b0;
              state       <= ST_IDLE;
            end
          end
        end
        ST_MEM_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_MEM_WAIT;
          end
        end
        ST_MEM_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              fault       <= 1'b1;
              fault_cause <= cause_q;
              busy        <= 1'b0;
              state       <= ST_IDLE;
            end else begin
              wr_en    <= 1'b1;
              wr_way   <= way_next;
              wr_index <= idx_c;
              wr_vpn   <= vpn_c;
              wr_ppn   <= ppn_c;
              wr_asid  <= asid_c;
              wr_attr  <= attr_c;
              state    <= ST_INSTALL;
            end
          end
        end
        ST_INSTALL: begin
          done      <= 1'b1;
          excv_addr <= vaddr_q;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));  // R8
  AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> done);  // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));  // R9
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
    (probe_req || mem_req_valid || wr_en) |-> busy);  // R7
  AST_EXCV_QUIET: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(excv_addr));  // R6
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    fault |-> !wr_en);  // R3
  AST_PROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    probe_req |=> !probe_req);  // R1
endmodule

// File: tb/ptw_refill_walker_tb.sv
`timescale 1ns/100ps
module ptw_refill_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pte_base, ring_asids, miss_vaddr, excv_addr, probe_va, probe_pa;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic [5:0]  miss_cause, fault_cause;
  logic        miss_valid, busy, done, fault, probe_req, probe_rsp_valid, probe_hit;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_err, wr_en;
  logic [1:0]  wr_way, wr_index;
  logic [19:0] wr_vpn, wr_ppn;
  logic [7:0]  wr_asid;
  logic [3:0]  wr_attr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [1:0]  exp_way = 2'd0;
  logic [31:0] exp_excv = 32'h0;

  always #2.5 clk = ~clk;

  ptw_refill_walker dut_i (
    .clk(clk), .rst(rst), .pte_base(pte_base), .ring_asids(ring_asids),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_cause(miss_cause),
    .busy(busy), .done(done), .fault(fault), .fault_cause(fault_cause),
    .excv_addr(excv_addr), .probe_req(probe_req), .probe_va(probe_va),
    .probe_rsp_valid(probe_rsp_valid), .probe_hit(probe_hit), .probe_pa(probe_pa),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .wr_en(wr_en), .wr_way(wr_way), .wr_index(wr_index), .wr_vpn(wr_vpn),
    .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_attr(wr_attr)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pte;
    logic        hit;
    logic        err;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 32'h0ABC_D027, 1'b1, 1'b0},
    '{32'h0040_1ABC, 32'h5555_5013, 1'b1, 1'b0},
    '{32'h8000_3000, 32'h0000_0000, 1'b0, 1'b0},
    '{32'h7FFF_F000, 32'h1111_1035, 1'b1, 1'b0},
    '{32'h0000_2000, 32'h2222_2001, 1'b1, 1'b1},
    '{32'hFFFF_FFFF, 32'hFFFF_F00F, 1'b1, 1'b0},
    '{32'h0000_0000, 32'h0000_1020, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [31:0] pte,
                          input logic hit, input logic err,
                          input logic [5:0] cause, input bit poke);
    logic [31:0] exp_pva;
    logic [31:0] pa;
    exp_pva = (pte_base | (va >> 10)) & 32'hFFFF_FFFC;
    pa = exp_pva ^ 32'h3000_0000;
    @(negedge clk);
    miss_valid = 1'b1; miss_vaddr = va; miss_cause = cause;
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R1 probe_req", probe_req, 1);
    chk("R1 probe_va", probe_va, exp_pva);
    chk("R7 busy after accept", busy, 1);
    if (poke) begin
      miss_valid = 1'b1; miss_vaddr = 32'hDEAD_B000; miss_cause = 6'h3F;
    end
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R1 probe pulse ends", probe_req, 0);
    if (poke) chk("R7 poke ignored probe_va", probe_va, exp_pva);
    probe_rsp_valid = 1'b1; probe_hit = hit; probe_pa = pa;
    @(negedge clk);
    probe_rsp_valid = 1'b0;
    if (!hit) begin
      chk("R2 fault", fault, 1);
      chk("R2 cause", fault_cause, cause);
      chk("R2 no mem req", mem_req_valid, 0);
      chk("R7 busy drops", busy, 0);
      chk("R8 no done", done, 0);
      @(negedge clk);
      chk("R8 fault pulse", fault, 0);
      chk("R6 excv kept", excv_addr, exp_excv);
      return;
    end
    chk("R9 req valid", mem_req_valid, 1);
    chk("R9 req addr", mem_req_addr, pa);
    @(negedge clk);
    chk("R9 req held", mem_req_valid, 1);
    chk("R9 addr held", mem_req_addr, pa);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R9 req drops", mem_req_valid, 0);
    mem_rsp_valid = 1'b1; mem_rsp_data = pte; mem_rsp_err = err;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    if (err) begin
      chk("R3 fault", fault, 1);
      chk("R3 cause", fault_cause, cause);
      chk("R3 no write", wr_en, 0);
      chk("R7 busy drops", busy, 0);
      @(negedge clk);
      chk("R3 still no write", wr_en, 0);
      chk("R6 excv kept", excv_addr, exp_excv);
      return;
    end
    exp_way = exp_way + 2'd1;
    chk("R4 wr_en", wr_en, 1);
    chk("R5 wr_way", wr_way, exp_way);
    chk("R4 index", wr_index, va[13:12]);
    chk("R4 vpn", wr_vpn, va[31:12]);
    chk("R4 ppn", wr_ppn, pte[31:12]);
    chk("R4 attr", wr_attr, pte[3:0]);
    chk("R4 asid", wr_asid, ring_asids[8*pte[5:4] +: 8]);
    chk("R8 done not yet", done, 0);
    @(negedge clk);
    exp_excv = va;
    chk("R8 done", done, 1);
    chk("R8 wr pulse", wr_en, 0);
    chk("R6 excv", excv_addr, va);
    chk("R7 busy drops", busy, 0);
    @(negedge clk);
    chk("R8 done pulse", done, 0);
    chk("R7 no second walk", probe_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    pte_base = 32'hC000_0000; ring_asids = 32'h0403_0201;
    miss_valid = 0; miss_vaddr = 0; miss_cause = 0;
    probe_rsp_valid = 0; probe_hit = 0; probe_pa = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; mem_rsp_err = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 fault", fault, 0);
    chk("R10 probe_req", probe_req, 0);
    chk("R10 mem_req_valid", mem_req_valid, 0);
    chk("R10 wr_en", wr_en, 0);
    chk("R10 excv", excv_addr, 0);

    for (int i = 0; i < NVEC; i++)
      run_walk(VECS[i].va, VECS[i].pte, VECS[i].hit, VECS[i].err,
               6'(6'h18 + i), i == 1);

    // R5: counter did not move on faults and wrapped through way 0
    chk("R5 final way", exp_way, 2'd1);

    // R4: ASID chosen by ring after changing the ring register
    ring_asids = 32'hA1B2_C3D4;
    run_walk(32'h0000_3000, 32'h0000_5030, 1'b1, 1'b0, 6'h05, 1'b0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule